// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the link reservations that pair a load-linked access with a later store-conditional. Completion events enter on one port, each carrying a line address, a request kind and the issuing agent's ID. A second port carries coherence-loss invalidations. The block holds a small table. Each entry stores a valid bit, a line tag, a lock flag and the owner agent. For every completion, the block reports whether the operation succeeded and whether its store data may be committed.

The table is the tracked set. A load-linked to a line that is not in the table claims an entry by round-robin replacement, which can evict another reservation. Any other completion to an untracked line reports success and changes nothing. A store-conditional that hits a tracked line succeeds only when that line is locked by the same agent. It always drops the lock, whatever the result. When an invalidation and a completion arrive in the same cycle, the invalidation is applied first.

Both input ports are plain valid strobes with no ready signal. The block accepts one completion and one invalidation in every cycle. The result appears exactly one cycle after its completion. It has no back-pressure, so the consumer must take every result in the cycle it is shown.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `res_valid` is 0 and no line is tracked. A store-conditional issued right after reset therefore reports success 1 and commit 1.
- R2: A load-linked sets the lock on its line and records `cmp_agent` as owner. A later store-conditional from the same agent to that line reports success 1.
- R3: A store-conditional to a tracked line that is unlocked, or locked by a different agent, reports success 0 and commit 0.
- R4: Every store-conditional that hits a tracked line clears its lock, whether it succeeds or fails. A second store-conditional to that line then fails.
- R5: An ordinary write (kind 2'b01) clears the lock only when the line is locked by the writing agent. A write from any other agent leaves the lock in place.
- R6: An invalidation clears the lock of line `inv_line` only when that line is locked by `inv_agent`. Any other invalidation has no effect.
- R7: A completion that is not a load-linked and targets an untracked line reports success 1 and leaves all lock state unchanged.
- R8: The kind encoding is 2'b00 read, 2'b01 write, 2'b10 load-linked, 2'b11 store-conditional. Success is 1 for read, write and load-linked. Commit is 1 for a write and for a successful store-conditional, and 0 otherwise.
- R9: A load-linked to an untracked line fills entries in round-robin order over DEPTH entries, evicting the oldest fill. A load-linked to a line already tracked reuses its entry and does not advance the order.
- R10: An invalidation and a completion in the same cycle act as if the invalidation came first.
- R11: `res_valid` is high exactly one cycle after each cycle in which `cmp_valid` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion event strobe |
| cmp_kind | input | 2 | Request kind (see R8) |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_agent | input | AGENT_W | Issuing agent ID |
| inv_valid | input | 1 | Coherence-loss invalidation strobe |
| inv_line | input | LINE_W | Line that lost permission |
| inv_agent | input | AGENT_W | Agent whose permission was lost |
| res_valid | output | 1 | Result strobe, one cycle after the completion |
| res_success | output | 1 | 1 = operation succeeded |
| res_commit | output | 1 | 1 = store data may be written |

## Verification
Some behaviour can be checked on every cycle. The assertions cover the one-cycle result timing and the per-kind success and commit values for read, write and load-linked. They also check that a store-conditional's commit always equals its success. Finally, a store-conditional from the same agent right after its own load-linked must succeed, and one from another agent must fail. Other behaviour depends on earlier history: lock clearing by writes and invalidations, the double store-conditional failure, round-robin eviction, and same-cycle invalidation ordering. Only the bench scenarios can show these, by comparing results against a reference table kept in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_LINK  = 2'b10,
    KIND_COND  = 2'b11
  } req_kind_e;
endpackage

// File: rtl/llsc_rr_alloc.sv
module llsc_rr_alloc #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic [DEPTH-1:0] grant
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (req)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_grant
    assign grant[g] = req && (ptr_q == PTR_W'(g));
  end
endmodule

// File: rtl/llsc_entry.sv
module llsc_entry
  import llsc_pkg::*;
#(
  parameter int LINE_W  = 8,
  parameter int AGENT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_valid,
  input  logic [LINE_W-1:0]  inv_line,
  input  logic [AGENT_W-1:0] inv_agent,
  input  logic               cmp_valid,
  input  req_kind_e          cmp_kind,
  input  logic [LINE_W-1:0]  cmp_line,
  input  logic [AGENT_W-1:0] cmp_agent,
  input  logic               fill_en,
  output logic               hit,
  output logic               own_lock
);
  logic               vld_q, lck_q;
  logic [LINE_W-1:0]  tag_q;
  logic [AGENT_W-1:0] own_q;
  logic               vld_d, lck_d;
  logic [LINE_W-1:0]  tag_d;
  logic [AGENT_W-1:0] own_d;
  logic               inv_clr, lck_mid;

  // invalidation is resolved before the completion looks at the lock
  assign inv_clr  = inv_valid && vld_q && lck_q && (tag_q == inv_line) && (own_q == inv_agent);
  assign lck_mid  = lck_q && !inv_clr;
  assign hit      = cmp_valid && vld_q && (tag_q == cmp_line);
  assign own_lock = lck_mid && (own_q == cmp_agent);

  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    own_d = own_q;
    lck_d = lck_mid;
    if (fill_en) begin
      vld_d = 1'b1;
      tag_d = cmp_line;
      lck_d = 1'b1;
      own_d = cmp_agent;
    end else if (hit) begin
      unique case (cmp_kind)
        KIND_LINK: begin
          lck_d = 1'b1;
          own_d = cmp_agent;
        end
        KIND_COND:  lck_d = 1'b0;
        KIND_WRITE: if (own_lock) lck_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lck_q <= 1'b0;
      tag_q <= '0;
      own_q <= '0;
    end else begin
      vld_q <= vld_d;
      lck_q <= lck_d;
      tag_q <= tag_d;
      own_q <= own_d;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int LINE_W  = 8,
  parameter int AGENT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_valid,
  input  logic [1:0]         cmp_kind,
  input  logic [LINE_W-1:0]  cmp_line,
  input  logic [AGENT_W-1:0] cmp_agent,
  input  logic               inv_valid,
  input  logic [LINE_W-1:0]  inv_line,
  input  logic [AGENT_W-1:0] inv_agent,
  output logic               res_valid,
  output logic               res_success,
  output logic               res_commit
);
  req_kind_e        kind;
  logic [DEPTH-1:0] hit_vec, lock_vec, fill_vec;
  logic             any_hit, sc_ok, fill_req;
  logic             succ_d, commit_d;

  assign kind     = req_kind_e'(cmp_kind);
  assign any_hit  = |hit_vec;
  assign sc_ok    = |(hit_vec & lock_vec);
  assign fill_req = cmp_valid && (kind == KIND_LINK) && !any_hit;

  llsc_rr_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (fill_req),
    .grant (fill_vec)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    llsc_entry #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .inv_valid (inv_valid),
      .inv_line  (inv_line),
      .inv_agent (inv_agent),
      .cmp_valid (cmp_valid),
      .cmp_kind  (kind),
      .cmp_line  (cmp_line),
      .cmp_agent (cmp_agent),
      .fill_en   (fill_vec[g]),
      .hit       (hit_vec[g]),
      .own_lock  (lock_vec[g])
    );
  end

  always_comb begin
    succ_d   = 1'b1;
    commit_d = 1'b0;
    unique case (kind)
      KIND_WRITE: commit_d = 1'b1;
      KIND_COND: begin
        succ_d   = !any_hit || sc_ok;
        commit_d = succ_d;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_success <= 1'b0;
      res_commit  <= 1'b0;
    end else begin
      res_valid   <= cmp_valid;
      res_success <= cmp_valid && succ_d;
      res_commit  <= cmp_valid && commit_d;
    end
  end
endmodule

// File: rtl/llsc_monitor_sva.sv
module llsc_monitor_sva #(
  parameter int LINE_W  = 8,
  parameter int AGENT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmp_valid,
  input logic [1:0]         cmp_kind,
  input logic [LINE_W-1:0]  cmp_line,
  input logic [AGENT_W-1:0] cmp_agent,
  input logic               inv_valid,
  input logic               res_valid,
  input logic               res_success,
  input logic               res_commit
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid); // R11
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid); // R11
  AST_READ_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b00) |=> (res_success && !res_commit)); // R8
  AST_WRITE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b01) |=> (res_success && res_commit)); // R8
  AST_LINK_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b10) |=> (res_success && !res_commit)); // R8
  AST_COND_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b11) |=> (res_commit == res_success)); // R8
  AST_LINK_THEN_OWN_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b10) ##1
    (cmp_valid && cmp_kind == 2'b11 && !inv_valid &&
     cmp_line == $past(cmp_line) && cmp_agent == $past(cmp_agent))
    |=> res_success); // R2
  AST_LINK_THEN_FOREIGN_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b10) ##1
    (cmp_valid && cmp_kind == 2'b11 &&
     cmp_line == $past(cmp_line) && cmp_agent != $past(cmp_agent))
    |=> !res_success); // R3
endmodule

bind llsc_monitor llsc_monitor_sva #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_valid   (cmp_valid),
  .cmp_kind    (cmp_kind),
  .cmp_line    (cmp_line),
  .cmp_agent   (cmp_agent),
  .inv_valid   (inv_valid),
  .res_valid   (res_valid),
  .res_success (res_success),
  .res_commit  (res_commit)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
  localparam int DEPTH   = 4;
  localparam int LINE_W  = 8;
  localparam int AGENT_W = 2;
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_LL = 2'b10, K_SC = 2'b11;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmp_valid = 1'b0;
  logic [1:0]         cmp_kind = '0;
  logic [LINE_W-1:0]  cmp_line = '0;
  logic [AGENT_W-1:0] cmp_agent = '0;
  logic               inv_valid = 1'b0;
  logic [LINE_W-1:0]  inv_line = '0;
  logic [AGENT_W-1:0] inv_agent = '0;
  logic               res_valid, res_success, res_commit;

  int n_checks = 0;
  int n_fail   = 0;

  // reference table
  logic               m_v   [DEPTH];
  logic               m_lk  [DEPTH];
  logic [LINE_W-1:0]  m_tag [DEPTH];
  logic [AGENT_W-1:0] m_own [DEPTH];
  int                 m_ptr;

  always #2 clk = ~clk;

  llsc_monitor #(.DEPTH(DEPTH), .LINE_W(LINE_W), .AGENT_W(AGENT_W)) i_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
    .cmp_line(cmp_line), .cmp_agent(cmp_agent), .inv_valid(inv_valid),
    .inv_line(inv_line), .inv_agent(inv_agent), .res_valid(res_valid),
    .res_success(res_success), .res_commit(res_commit)
  );

  function automatic int find_line(input logic [LINE_W-1:0] l);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_tag[i] == l) return i;
    return -1;
  endfunction

  // expected {success, commit} against the table after invalidation
  function automatic logic [1:0] predict(input logic [1:0] k, input logic [LINE_W-1:0] l,
                                         input logic [AGENT_W-1:0] a);
    int h = find_line(l);
    logic s;
    case (k)
      K_WR: return 2'b11;
      K_SC: begin
        s = (h < 0) ? 1'b1 : (m_lk[h] && m_own[h] == a);
        return {s, s};
      end
      default: return 2'b10;
    endcase
  endfunction

  task automatic model_inv(input logic [LINE_W-1:0] l, input logic [AGENT_W-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_lk[i] && m_tag[i] == l && m_own[i] == a) m_lk[i] = 1'b0;
  endtask

  task automatic model_cmp(input logic [1:0] k, input logic [LINE_W-1:0] l,
                           input logic [AGENT_W-1:0] a);
    int h = find_line(l);
    if (k == K_LL) begin
      if (h < 0) begin
        h = m_ptr;
        m_v[h] = 1'b1; m_tag[h] = l;
        m_ptr = (m_ptr + 1) % DEPTH;
      end
      m_lk[h] = 1'b1; m_own[h] = a;
    end else if (h >= 0) begin
      if (k == K_SC) m_lk[h] = 1'b0;
      else if (k == K_WR && m_lk[h] && m_own[h] == a) m_lk[h] = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,success,commit} got %b expected %b", req, got, exp);
    end
  endtask

  // drive at a falling edge, check at the next one
  task automatic apply(input string req, input logic [1:0] k, input logic [LINE_W-1:0] l,
                       input logic [AGENT_W-1:0] a, input logic iv = 1'b0,
                       input logic [LINE_W-1:0] il = '0, input logic [AGENT_W-1:0] ia = '0);
    logic [1:0] e;
    cmp_valid = 1'b1; cmp_kind = k; cmp_line = l; cmp_agent = a;
    inv_valid = iv; inv_line = il; inv_agent = ia;
    if (iv) model_inv(il, ia);
    e = predict(k, l, a);
    model_cmp(k, l, a);
    @(negedge clk);
    check(req, {res_valid, res_success, res_commit}, {1'b1, e});
  endtask

  task automatic idle(input string req, input logic iv = 1'b0,
                      input logic [LINE_W-1:0] il = '0, input logic [AGENT_W-1:0] ia = '0);
    cmp_valid = 1'b0; inv_valid = iv; inv_line = il; inv_agent = ia;
    if (iv) model_inv(il, ia);
    @(negedge clk);
    check(req, {res_valid, res_success, res_commit}, 3'b000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stimulus
    logic [1:0] k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_lk[i] = 1'b0; m_tag[i] = '0; m_own[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", {res_valid, res_success, res_commit}, 3'b000);
    apply("R1 empty table", K_SC, 8'h10, 2'd0);
    // R2 / R4
    apply("R2 link", K_LL, 8'h20, 2'd1);
    apply("R2 own cond", K_SC, 8'h20, 2'd1);
    apply("R4 second cond fails", K_SC, 8'h20, 2'd1);
    // R3
    apply("R3 link", K_LL, 8'h21, 2'd0);
    apply("R3 foreign cond", K_SC, 8'h21, 2'd2);
    apply("R4 owner after failed cond", K_SC, 8'h21, 2'd0);
    // R5
    apply("R5 link", K_LL, 8'h22, 2'd3);
    apply("R5 foreign write", K_WR, 8'h22, 2'd1);
    apply("R5 lock kept", K_SC, 8'h22, 2'd3);
    apply("R5 relink", K_LL, 8'h22, 2'd3);
    apply("R5 owner write", K_WR, 8'h22, 2'd3);
    apply("R5 lock cleared", K_SC, 8'h22, 2'd3);
    // R6
    apply("R6 link", K_LL, 8'h23, 2'd2);
    idle("R6 foreign inv", 1'b1, 8'h23, 2'd1);
    idle("R6 other line inv", 1'b1, 8'h24, 2'd2);
    apply("R6 lock kept", K_SC, 8'h23, 2'd2);
    apply("R6 relink", K_LL, 8'h23, 2'd2);
    idle("R6 owner inv", 1'b1, 8'h23, 2'd2);
    apply("R6 lock cleared", K_SC, 8'h23, 2'd2);
    // R10
    apply("R10 link", K_LL, 8'h23, 2'd1);
    apply("R10 inv then cond", K_SC, 8'h23, 2'd1, 1'b1, 8'h23, 2'd1);
    apply("R10 inv then link", K_LL, 8'h23, 2'd0, 1'b1, 8'h23, 2'd0);
    apply("R10 link survives", K_SC, 8'h23, 2'd0);
    // R7 / R8
    apply("R7 untracked write", K_WR, 8'h77, 2'd1);
    apply("R7 untracked read", K_RD, 8'h77, 2'd1);
    apply("R7 untracked cond", K_SC, 8'h78, 2'd3);
    apply("R8 tracked read", K_RD, 8'h23, 2'd2);
    // R9: fill four fresh lines, a fifth evicts the oldest
    apply("R9 fill a", K_LL, 8'h40, 2'd0);
    apply("R9 fill b", K_LL, 8'h41, 2'd0);
    apply("R9 fill c", K_LL, 8'h42, 2'd0);
    apply("R9 fill d", K_LL, 8'h43, 2'd0);
    apply("R9 relink b", K_LL, 8'h41, 2'd0);
    apply("R9 fill e", K_LL, 8'h44, 2'd0);
    apply("R9 evicted cond", K_SC, 8'h40, 2'd1);
    apply("R9 kept cond", K_SC, 8'h42, 2'd1);
    // R11 idle gap
    idle("R11 idle");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      k = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0)
        idle("R11 random idle", ($urandom_range(0, 3) == 0),
             8'($urandom_range(0, 5)), 2'($urandom_range(0, 3)));
      else
        apply("R8 random", k, 8'($urandom_range(0, 5)), 2'($urandom_range(0, 3)),
              ($urandom_range(0, 3) == 0), 8'($urandom_range(0, 5)),
              2'($urandom_range(0, 3)));
    end
    idle("R11 final");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule